// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block is the doorbell side of a storage controller's register file. The host writes 32-bit values at byte offsets inside a doorbell window. Each slot in that window belongs to one queue. A slot either carries a new tail for a submission queue, which the host has filled, or a new head for a completion queue, which the host has drained. The block keeps one tail register per submission queue and one head register per completion queue. The admin pair always uses queue number 0, and a parameter sets how many IO pairs follow it.

The slot layout is interleaved. The submission slot of queue X comes first and the completion slot of the same queue follows it. The spacing between slots is a programmable power-of-two stride. The command fetch logic supplies its internal submission head, and the completion posting logic supplies its completion tail. The block compares these with the stored pointers, using zero-based queue sizes, and reports per-queue flags: work pending, queue full, and completions not yet consumed. Doorbell values that are out of range are dropped and recorded in a sticky error flag. Clearing the controller enable returns all state to zero.

Top module: `qdb_decoder`

## Requirements
- R1: After reset every submission tail, every completion head and the error flag read 0.
- R2: A write at byte offset 0x1000 + 2·X·S, where S is the stride, loads the low PTR_W bits of the data into the submission tail of queue X. The new value is visible on the next clock cycle.
- R3: A write at byte offset 0x1000 + (2·X+1)·S loads the completion head of queue X. The new value is visible on the next clock cycle.
- R4: The stride S in bytes is 4 shifted left by `stride_sel` (0..15). Changing `stride_sel` moves every slot except slot 0.
- R5: A decoded write is dropped, and sets the error flag, in either of two cases: its data exceeds that queue's zero-based size, or it has any bit set at or above bit PTR_W. Once set, the flag stays 1 until the controller enable is cleared.
- R6: A write is ignored without touching any pointer or the error flag in any of these cases: it lies below 0x1000, it is not at the start of a slot, or it decodes to a queue number at or above 1+NUM_IO.
- R7: `sq_nonempty[X]` is 1 exactly when submission tail X differs from `sq_head_in` for queue X.
- R8: `sq_full[X]` is 1 exactly when (tail+1, wrapped to 0 past the zero-based size) equals `sq_head_in` for queue X.
- R9: `cq_pending[X]` is 1 when `cq_tail_in` for queue X differs from completion head X. `cq_full[X]` is 1 when (`cq_tail_in`+1, wrapped past the size) equals completion head X.
- R10: While `ctrl_en` is 0, all pointers and the error flag are forced to 0 on each clock, and doorbell writes have no effect.
- R11: Queue 0 is the admin pair: its submission slot is at offset 0x1000 and its completion slot is one stride above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_en | input | 1 | Controller enable; 0 clears all state |
| stride_sel | input | 4 | Doorbell stride exponent |
| wr_en | input | 1 | Write strobe |
| wr_offset | input | OFFS_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| sq_size | input | NQ·PTR_W | Zero-based submission queue sizes, queue X at bits X·PTR_W |
| cq_size | input | NQ·PTR_W | Zero-based completion queue sizes |
| sq_head_in | input | NQ·PTR_W | Internal submission heads from command fetch |
| cq_tail_in | input | NQ·PTR_W | Internal completion tails from completion posting |
| sq_tail | output | NQ·PTR_W | Host submission tails |
| cq_head | output | NQ·PTR_W | Host completion heads |
| sq_nonempty | output | NQ | Submission queue has commands to fetch |
| sq_full | output | NQ | Submission queue full |
| cq_pending | output | NQ | Completion queue holds unconsumed entries |
| cq_full | output | NQ | Completion queue has no free entry |
| dbell_err | output | 1 | Sticky invalid-doorbell flag |

## Verification
The bench builds the block with two IO pairs (three queues), 16-bit pointers and a 16-bit offset. The queue sizes are small and differ between queues: 3, 5, 7 and 15. With them, wraparound fullness and size-limit rejection are reached within a few writes. The bench exercises stride exponents 0 and 2. That is enough to show slots moving, an old address becoming misaligned, and an offset that maps to a non-existent fourth queue.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam logic [31:0] DB_BASE = 32'h0000_1000;

  // Advance a pointer by one, wrapping to 0 past a zero-based size.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input logic [31:0] size_zb);
    return (v >= size_zb) ? 32'd0 : v + 32'd1;
  endfunction
endpackage

// File: rtl/qdb_addr_dec.sv
module qdb_addr_dec #(
  parameter int OFFS_W = 16,
  parameter int NQ     = 3
) (
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_offset,
  input  logic [3:0]        stride_sel,
  output logic [NQ-1:0]     sq_sel,
  output logic [NQ-1:0]     cq_sel
);
  import qdb_pkg::*;

  logic              in_region;
  logic [OFFS_W-1:0] rel;
  logic [4:0]        sh;
  logic [OFFS_W-1:0] low_mask;
  logic [OFFS_W-1:0] slot;
  logic              aligned;

  always_comb begin
    in_region = wr_offset >= OFFS_W'(DB_BASE);
    rel       = wr_offset - OFFS_W'(DB_BASE);
    sh        = 5'(stride_sel) + 5'd2;
    low_mask  = (OFFS_W'(1) << sh) - OFFS_W'(1);
    aligned   = (rel & low_mask) == '0;
    slot      = rel >> sh;
  end

  for (genvar q = 0; q < NQ; q++) begin : g_sel
    logic hit;
    assign hit       = wr_en && in_region && aligned && ((slot >> 1) == OFFS_W'(q));
    assign sq_sel[q] = hit && !slot[0];
    assign cq_sel[q] = hit &&  slot[0];
  end
endmodule

// File: rtl/qdb_ptr_slot.sv
module qdb_ptr_slot #(
  parameter int PTR_W    = 16,
  parameter bit PRODUCER = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_hit,
  input  logic [31:0]      wr_data,
  input  logic [PTR_W-1:0] size_zb,
  input  logic [PTR_W-1:0] peer,
  output logic [PTR_W-1:0] ptr,
  output logic             differs,
  output logic             full,
  output logic             bad
);
  import qdb_pkg::*;

  logic             val_ok;
  logic             ptr_en;
  logic [PTR_W-1:0] ptr_nxt;
  logic [PTR_W-1:0] prod;
  logic [PTR_W-1:0] cons;

  always_comb begin
    val_ok  = ((wr_data >> PTR_W) == 32'd0) && (wr_data[PTR_W-1:0] <= size_zb);
    ptr_en  = clr || (wr_hit && val_ok);
    ptr_nxt = clr ? '0 : wr_data[PTR_W-1:0];
    bad     = wr_hit && !val_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_nxt;
  end

  if (PRODUCER) begin : g_prod
    assign prod = ptr;
    assign cons = peer;
  end else begin : g_cons
    assign prod = peer;
    assign cons = ptr;
  end

  assign differs = ptr != peer;
  assign full    = PTR_W'(wrap_inc(32'(prod), 32'(size_zb))) == cons;
endmodule

// File: rtl/qdb_decoder.sv
module qdb_decoder #(
  parameter int NUM_IO = 2,
  parameter int PTR_W  = 16,
  parameter int OFFS_W = 16,
  localparam int NQ    = NUM_IO + 1,
  localparam int VEC_W = NQ * PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [3:0]        stride_sel,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] wr_offset,
  input  logic [31:0]       wr_data,
  input  logic [VEC_W-1:0]  sq_size,
  input  logic [VEC_W-1:0]  cq_size,
  input  logic [VEC_W-1:0]  sq_head_in,
  input  logic [VEC_W-1:0]  cq_tail_in,
  output logic [VEC_W-1:0]  sq_tail,
  output logic [VEC_W-1:0]  cq_head,
  output logic [NQ-1:0]     sq_nonempty,
  output logic [NQ-1:0]     sq_full,
  output logic [NQ-1:0]     cq_pending,
  output logic [NQ-1:0]     cq_full,
  output logic              dbell_err
);
  logic [1:0]    rst_q;
  logic          rst_i_n;
  logic [NQ-1:0] sq_sel;
  logic [NQ-1:0] cq_sel;
  logic [NQ-1:0] sq_bad;
  logic [NQ-1:0] cq_bad;
  logic          clr;
  logic          err_nxt;

  // reset synchronizer: asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];
  assign clr     = !ctrl_en;

  qdb_addr_dec #(.OFFS_W(OFFS_W), .NQ(NQ)) u_dec (
    .wr_en      (wr_en),
    .wr_offset  (wr_offset),
    .stride_sel (stride_sel),
    .sq_sel     (sq_sel),
    .cq_sel     (cq_sel)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    qdb_ptr_slot #(.PTR_W(PTR_W), .PRODUCER(1'b1)) u_sq (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .clr     (clr),
      .wr_hit  (sq_sel[q]),
      .wr_data (wr_data),
      .size_zb (sq_size[q*PTR_W +: PTR_W]),
      .peer    (sq_head_in[q*PTR_W +: PTR_W]),
      .ptr     (sq_tail[q*PTR_W +: PTR_W]),
      .differs (sq_nonempty[q]),
      .full    (sq_full[q]),
      .bad     (sq_bad[q])
    );
    qdb_ptr_slot #(.PTR_W(PTR_W), .PRODUCER(1'b0)) u_cq (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .clr     (clr),
      .wr_hit  (cq_sel[q]),
      .wr_data (wr_data),
      .size_zb (cq_size[q*PTR_W +: PTR_W]),
      .peer    (cq_tail_in[q*PTR_W +: PTR_W]),
      .ptr     (cq_head[q*PTR_W +: PTR_W]),
      .differs (cq_pending[q]),
      .full    (cq_full[q]),
      .bad     (cq_bad[q])
    );
  end

  always_comb begin
    err_nxt = clr ? 1'b0 : (dbell_err || (|sq_bad) || (|cq_bad));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) dbell_err <= 1'b0;
    else          dbell_err <= err_nxt;
  end
endmodule

// File: rtl/qdb_checker.sv
module qdb_checker #(
  parameter int NQ    = 3,
  parameter int PTR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_en,
  input logic                wr_en,
  input logic [NQ*PTR_W-1:0] sq_tail,
  input logic [NQ*PTR_W-1:0] cq_head,
  input logic [NQ*PTR_W-1:0] sq_size,
  input logic [NQ-1:0]       sq_full,
  input logic [NQ-1:0]       sq_nonempty,
  input logic                dbell_err
);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (sq_tail == '0 && cq_head == '0 && !dbell_err));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctrl_en) |=> ($stable(sq_tail) && $stable(cq_head)));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbell_err && ctrl_en) |=> dbell_err);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbell_err) |-> $past(wr_en));

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    p_full_ne_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_size[q*PTR_W +: PTR_W] != '0 && sq_full[q]) |-> sq_nonempty[q]);
  end
endmodule

bind qdb_decoder qdb_checker #(.NQ(NQ), .PTR_W(PTR_W)) u_qdb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_en     (ctrl_en),
  .wr_en       (wr_en),
  .sq_tail     (sq_tail),
  .cq_head     (cq_head),
  .sq_size     (sq_size),
  .sq_full     (sq_full),
  .sq_nonempty (sq_nonempty),
  .dbell_err   (dbell_err)
);

// File: tb/test_qdb_decoder.sv
`timescale 1ns/1ps
module test_qdb_decoder;
  localparam int NQ = 3;
  localparam int PW = 16;
  localparam int VW = NQ * PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_en = 1'b1;
  logic [3:0]    stride_sel = 4'd0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_offset = '0;
  logic [31:0]   wr_data = '0;
  logic [VW-1:0] sq_size, cq_size;
  logic [VW-1:0] sq_head_in = '0;
  logic [VW-1:0] cq_tail_in = '0;
  logic [VW-1:0] sq_tail, cq_head;
  logic [NQ-1:0] sq_nonempty, sq_full, cq_pending, cq_full;
  logic          dbell_err;

  always #4 clk = ~clk;

  qdb_decoder #(.NUM_IO(2), .PTR_W(PW), .OFFS_W(16)) i_qdb_decoder (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .stride_sel(stride_sel),
    .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
    .sq_size(sq_size), .cq_size(cq_size), .sq_head_in(sq_head_in),
    .cq_tail_in(cq_tail_in), .sq_tail(sq_tail), .cq_head(cq_head),
    .sq_nonempty(sq_nonempty), .sq_full(sq_full), .cq_pending(cq_pending),
    .cq_full(cq_full), .dbell_err(dbell_err)
  );

  typedef struct {
    logic [VW-1:0] sq;
    logic [VW-1:0] cq;
    logic          err;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  exp_t          cur;
  logic [VW-1:0] m_sq = '0;
  logic [VW-1:0] m_cq = '0;
  logic          m_err = 1'b0;
  int            sq_sz[NQ] = '{7, 3, 15};
  int            cq_sz[NQ] = '{7, 5, 15};
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  initial begin
    for (int q = 0; q < NQ; q++) begin
      sq_size[q*PW +: PW] = PW'(sq_sz[q]);
      cq_size[q*PW +: PW] = PW'(cq_sz[q]);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compares scoreboard items against the registered outputs
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      chk({cur.tag, " sq_tail"}, 64'(sq_tail), 64'(cur.sq));
      chk({cur.tag, " cq_head"}, 64'(cq_head), 64'(cur.cq));
      chk({cur.tag, " dbell_err"}, 64'(dbell_err), 64'(cur.err));
    end
  end

  // driver: kind 0 = no queue decoded, 1 = submission, 2 = completion
  task automatic db_write(input logic [15:0] off, input logic [31:0] data,
                          input int kind, input int q, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 1'b1; wr_offset = off; wr_data = data;
    @(posedge clk);
    if (ctrl_en && kind != 0) begin
      if (data > 32'(kind == 1 ? sq_sz[q] : cq_sz[q])) m_err = 1'b1;
      else if (kind == 1) m_sq[q*PW +: PW] = data[PW-1:0];
      else                m_cq[q*PW +: PW] = data[PW-1:0];
    end
    e.sq = m_sq; e.cq = m_cq; e.err = m_err; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    settle();
    // R1: reset state
    chk("R1 sq_tail", 64'(sq_tail), 0);
    chk("R1 cq_head", 64'(cq_head), 0);
    chk("R1 dbell_err", 64'(dbell_err), 0);
    chk("R1 flags", {sq_nonempty, sq_full, cq_pending, cq_full}, 0);

    // stride 4 bytes
    db_write(16'h1000, 5, 1, 0, "R2 R11 admin sq tail");
    db_write(16'h1004, 3, 2, 0, "R3 R11 admin cq head");
    db_write(16'h1008, 2, 1, 1, "R2 io1 sq tail");
    db_write(16'h1014, 9, 2, 2, "R3 io2 cq head");

    // R7: pending commands against internal head
    settle();
    chk("R7 nonempty q0", 64'(sq_nonempty[0]), 1);
    sq_head_in[0 +: PW] = 16'd5;
    settle();
    chk("R7 empty q0", 64'(sq_nonempty[0]), 0);

    // R8: io1 size 3, tail 2
    sq_head_in[PW +: PW] = 16'd3;
    settle();
    chk("R8 full q1", 64'(sq_full[1]), 1);
    sq_head_in[PW +: PW] = 16'd0;
    settle();
    chk("R8 not full q1", 64'(sq_full[1]), 0);
    db_write(16'h1008, 3, 1, 1, "R8 io1 tail at size");
    settle();
    chk("R8 wrap full q1", 64'(sq_full[1]), 1);
    chk("R7 nonempty q1", 64'(sq_nonempty[1]), 1);

    // R9: io2 completion head 9
    cq_tail_in[2*PW +: PW] = 16'd9;
    settle();
    chk("R9 no pending q2", 64'(cq_pending[2]), 0);
    chk("R9 not full q2", 64'(cq_full[2]), 0);
    cq_tail_in[2*PW +: PW] = 16'd8;
    settle();
    chk("R9 pending q2", 64'(cq_pending[2]), 1);
    chk("R9 full q2", 64'(cq_full[2]), 1);

    // R6: non-decoding writes
    db_write(16'h0FFC, 1, 0, 0, "R6 below window");
    db_write(16'h1002, 1, 0, 0, "R6 misaligned");
    db_write(16'h1018, 1, 0, 0, "R6 queue 3 absent");

    // R4: stride 16 bytes
    stride_sel = 4'd2;
    db_write(16'h1020, 1, 1, 1, "R4 io1 sq at stride 16");
    db_write(16'h1030, 2, 2, 1, "R4 io1 cq at stride 16");
    db_write(16'h1010, 4, 2, 0, "R4 R11 admin cq at stride 16");
    db_write(16'h1008, 0, 0, 0, "R4 old slot misaligned");
    db_write(16'h1060, 1, 0, 0, "R6 R4 queue 3 at stride 16");

    // R5: out-of-range values
    db_write(16'h1020, 4, 1, 1, "R5 value above size");
    db_write(16'h1020, 32'h0001_0001, 1, 1, "R5 upper bits set");
    db_write(16'h1020, 0, 1, 1, "R5 valid after error");

    // R10: controller disable
    @(negedge clk);
    ctrl_en = 1'b0;
    @(posedge clk);
    m_sq = '0; m_cq = '0; m_err = 1'b0;
    cur.sq = m_sq; cur.cq = m_cq; cur.err = m_err; cur.tag = "R10 clear";
    sb.push_back(cur);
    db_write(16'h1000, 1, 1, 0, "R10 write while disabled");
    @(negedge clk);
    ctrl_en = 1'b1;
    db_write(16'h1000, 6, 1, 0, "R10 R2 write after enable");

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule